// File: doc/BRIEF.md
# Lockable Software Reset Bank

This block gives software direct control over a set of peripheral reset lines. Each channel owns two one-bit registers on a plain 32-bit read/write bus. One is a control bit whose value drives that channel's active-low reset output. The other is a lock-enable bit. Software writes 0 to the control bit to hold a peripheral in reset and writes 1 to let it run. Writing 0 and then 1 produces a single reset pulse.

Once software clears a channel's lock-enable bit, the channel is frozen. Writes to its control bit have no effect from then on, and the lock cannot be reopened until the next system reset. Boot code typically sets every line the way it wants and then locks the channels that later, less trusted code must not touch. Synchronising the reset outputs into other clock domains is left to logic downstream.

Top module: `swrst_bank`

## Requirements
- R1: After system reset, every lock-enable bit reads 1, every control bit reads 1, and every bit of `rst_n_o` is 1.
- R2: Channel i's lock-enable register is at byte address LOCK_BASE+4*i and its control register is at CTRL_BASE+4*i. The defaults are LOCK_BASE=0x00 and CTRL_BASE=0x40. Any other address, including an unaligned one or one past the last channel, reads as 0, and a write to it changes nothing.
- R3: A write to an unlocked channel's control register stores bit 0 of the write data. From the clock after the write, `rst_n_o[i]` equals that bit: 0 holds the peripheral in reset and 1 releases it.
- R4: Writing a value whose bit 0 is 0 to a lock-enable register clears it. Writing a value whose bit 0 is 1 never sets it again.
- R5: While a channel's lock-enable bit is 0, writes to its control register are ignored, and its reset output keeps its value.
- R6: A read of a control register returns the stored value in bit 0, whether or not the channel is locked.
- R7: Only bit 0 of each register is implemented. Read data bits 31..1 are always 0, and write data bits 31..1 are ignored.
- R8: A read request produces `rsp_valid` high, with its data, on the clock after it is accepted. `rsp_valid` is low after a write or an idle cycle.
- R9: A write to one channel's registers leaves every other channel's control bit, lock-enable bit and reset output unchanged.
- R10: Writing 0 and then 1 to a control register on back-to-back clocks holds that reset output low for exactly one clock.
- R11: A lock persists until system reset. System reset reopens the lock and releases the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data; only bit 0 is used |
| rsp_valid | output | 1 | Read data valid, one clock after a read request |
| rsp_rdata | output | 32 | Read data |
| rst_n_o | output | N_CH | Active-low reset outputs, one per channel |

## Verification
The bench builds the block with its defaults: eight channels, an 8-bit address, lock-enable registers from 0x00 and control registers from 0x40. With eight channels, both the last mapped word (0x1C and 0x5C) and the first unmapped word past each window (0x20 and 0x60) fall within reach. That lets the bench probe the edges of both windows, as well as unaligned addresses inside them. The one-clock pulse and the locked-while-held case are exercised on separate channels, so a leak of one channel's write into its neighbours shows up on `rst_n_o`.

// File: rtl/swrst_pkg.sv
package swrst_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned MAX_CH  = 32;
  localparam int unsigned STRIDE  = 4;

  typedef struct packed {
    logic lock_en;
    logic ctrl;
  } chan_state_t;
endpackage

// File: rtl/swrst_decode.sv
module swrst_decode #(
  parameter int unsigned N_CH      = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned LOCK_BASE = 32'h00,
  parameter int unsigned CTRL_BASE = 32'h40
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_CH-1:0]   lock_sel,
  output logic [N_CH-1:0]   ctrl_sel
);
  import swrst_pkg::*;

  for (genvar i = 0; i < N_CH; i++) begin : g_sel
    localparam int unsigned LOCK_ADDR = LOCK_BASE + STRIDE * i;
    localparam int unsigned CTRL_ADDR = CTRL_BASE + STRIDE * i;
    assign lock_sel[i] = (addr == LOCK_ADDR[ADDR_W-1:0]);
    assign ctrl_sel[i] = (addr == CTRL_ADDR[ADDR_W-1:0]);
  end
endmodule

// File: rtl/swrst_chan.sv
module swrst_chan (
  input  logic clk,
  input  logic rst,
  input  logic wr_lock,
  input  logic wr_ctrl,
  input  logic wbit,
  output swrst_pkg::chan_state_t state
);
  logic lock_q;
  logic ctrl_q;

  // Lock-enable only ever falls; a 1 written to it is dropped.
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b1;
    end else if (wr_lock && !wbit) begin
      lock_q <= 1'b0;
    end
  end

  // Control bit is gated by the lock as it stood before this edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= 1'b1;
    end else if (wr_ctrl && lock_q) begin
      ctrl_q <= wbit;
    end
  end

  assign state.lock_en = lock_q;
  assign state.ctrl    = ctrl_q;

  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    !lock_q |=> !lock_q);

  a_r5_locked_hold: assert property (@(posedge clk) disable iff (rst)
    !lock_q |=> $stable(ctrl_q));

  a_r3_ctrl_takes_write: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && lock_q) |=> (ctrl_q == $past(wbit)));

  a_r9_untouched_stable: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> $stable(ctrl_q));
endmodule

// File: rtl/swrst_rdmux.sv
module swrst_rdmux #(
  parameter int unsigned N_CH = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rd_req,
  input  logic [N_CH-1:0]           lock_sel,
  input  logic [N_CH-1:0]           ctrl_sel,
  input  logic [N_CH-1:0]           lock_vec,
  input  logic [N_CH-1:0]           ctrl_vec,
  output logic                      rsp_valid,
  output logic [swrst_pkg::DATA_W-1:0] rsp_rdata
);
  import swrst_pkg::*;

  logic hit_bit;

  always_comb begin
    hit_bit = |((lock_sel & lock_vec) | (ctrl_sel & ctrl_vec));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_rdata <= rd_req ? {{(DATA_W-1){1'b0}}, hit_bit} : '0;
    end
  end

  a_r8_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rsp_valid);

  a_r8_no_rsp_idle: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rsp_valid);

  a_r7_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_rdata[DATA_W-1:1] == '0));
endmodule

// File: rtl/swrst_bank.sv
module swrst_bank #(
  parameter int unsigned N_CH      = 8,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned LOCK_BASE = 32'h00,
  parameter int unsigned CTRL_BASE = 32'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [N_CH-1:0]   rst_n_o
);
  import swrst_pkg::*;

  if (N_CH < 1 || N_CH > MAX_CH) begin : g_bad_count
    $error("swrst_bank: N_CH must be 1..32");
  end

  logic              wr_req;
  logic              rd_req;
  logic [N_CH-1:0]   lock_sel;
  logic [N_CH-1:0]   ctrl_sel;
  logic [N_CH-1:0]   lock_vec;
  logic [N_CH-1:0]   ctrl_vec;

  assign wr_req = req_valid &&  req_write;
  assign rd_req = req_valid && !req_write;

  swrst_decode #(
    .N_CH(N_CH), .ADDR_W(ADDR_W), .LOCK_BASE(LOCK_BASE), .CTRL_BASE(CTRL_BASE)
  ) u_dec (
    .addr(req_addr), .lock_sel(lock_sel), .ctrl_sel(ctrl_sel)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    chan_state_t st;
    swrst_chan u_ch (
      .clk(clk), .rst(rst),
      .wr_lock(wr_req && lock_sel[i]),
      .wr_ctrl(wr_req && ctrl_sel[i]),
      .wbit(req_wdata[0]),
      .state(st)
    );
    assign lock_vec[i] = st.lock_en;
    assign ctrl_vec[i] = st.ctrl;
  end

  // The control flops drive the outputs directly, so they are registered.
  assign rst_n_o = ctrl_vec;

  swrst_rdmux #(.N_CH(N_CH)) u_rd (
    .clk(clk), .rst(rst), .rd_req(rd_req),
    .lock_sel(lock_sel), .ctrl_sel(ctrl_sel),
    .lock_vec(lock_vec), .ctrl_vec(ctrl_vec),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  a_r5_locked_out_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_req && |(ctrl_sel & ~lock_vec)) |=> (rst_n_o == $past(rst_n_o)));
endmodule

// File: tb/sim_swrst_bank.sv
module sim_swrst_bank;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [N-1:0] rst_n_o;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  swrst_bank u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rst_n_o(rst_n_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R8 rsp_valid after read", {31'b0, rsp_valid}, 32'd1);
    d = rsp_rdata;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    check("R1 outputs released", {24'b0, rst_n_o}, 32'hFF);
    for (int i = 0; i < N; i++) begin
      rd(8'(4*i), d);        check("R1 lock-enable", d, 32'd1);
      rd(8'(8'h40 + 4*i), d); check("R1 control", d, 32'd1);
    end
  endtask

  task automatic t_hold_release();
    logic [31:0] d;
    wr(8'h4C, 32'd0);
    check("R3 hold ch3", {24'b0, rst_n_o}, 32'hF7);
    rd(8'h4C, d); check("R6 read held ctrl", d, 32'd0);
    wr(8'h4C, 32'd1);
    check("R3 release ch3", {24'b0, rst_n_o}, 32'hFF);
    check("R8 no rsp after write", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic t_pulse();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h40; req_wdata = 32'd0;
    @(posedge clk); @(negedge clk);
    check("R10 pulse low", {24'b0, rst_n_o}, 32'hFE);
    req_wdata = 32'd1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    check("R10 pulse one clock", {24'b0, rst_n_o}, 32'hFF);
  endtask

  task automatic t_upper_bits();
    logic [31:0] d;
    wr(8'h54, 32'hFFFF_FFFE);
    check("R7 upper write bits ignored", {24'b0, rst_n_o}, 32'hDF);
    rd(8'h54, d); check("R7 read ctrl bit0 only", d, 32'd0);
    wr(8'h54, 32'h0000_0001);
    rd(8'h54, d); check("R7 ctrl back to 1", d, 32'd1);
    rd(8'h14, d); check("R7 lock upper zero", d, 32'd1);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h20, 32'd0); wr(8'h60, 32'd0); wr(8'h42, 32'd0); wr(8'h01, 32'd0);
    check("R2 unmapped writes no effect", {24'b0, rst_n_o}, 32'hFF);
    rd(8'h20, d); check("R2 past lock window", d, 32'd0);
    rd(8'h60, d); check("R2 past ctrl window", d, 32'd0);
    rd(8'h41, d); check("R2 unaligned", d, 32'd0);
    rd(8'h1C, d); check("R2 last lock", d, 32'd1);
    rd(8'h00, d); check("R2 lock0 kept by unaligned write", d, 32'd1);
    wr(8'h5C, 32'd0);
    check("R2 last ctrl", {24'b0, rst_n_o}, 32'h7F);
    wr(8'h5C, 32'd1);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(8'h48, 32'd0);
    wr(8'h08, 32'd0);
    rd(8'h08, d); check("R4 lock cleared", d, 32'd0);
    wr(8'h48, 32'd1);
    check("R5 locked write ignored", {24'b0, rst_n_o}, 32'hFB);
    rd(8'h48, d); check("R6 read ctrl while locked", d, 32'd0);
    wr(8'h08, 32'd1);
    rd(8'h08, d); check("R4 lock not reopened", d, 32'd0);
    wr(8'h48, 32'd1);
    check("R5 still held", {24'b0, rst_n_o}, 32'hFB);
    wr(8'h58, 32'd0);
    check("R9 other channel free", {24'b0, rst_n_o}, 32'hBB);
    wr(8'h58, 32'd1);
    rd(8'h18, d); check("R9 other lock untouched", d, 32'd1);
  endtask

  task automatic t_reset_again();
    logic [31:0] d;
    do_reset();
    check("R11 output released", {24'b0, rst_n_o}, 32'hFF);
    rd(8'h08, d); check("R11 lock reopened", d, 32'd1);
    wr(8'h48, 32'd0);
    check("R11 ctrl writable", {24'b0, rst_n_o}, 32'hFB);
  endtask

  initial begin
    fork
      begin
        do_reset();
        t_reset_state();
        t_hold_release();
        t_pulse();
        t_upper_bits();
        t_unmapped();
        t_lock();
        t_reset_again();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule